// File: doc/BRIEF.md
# Multi-Format Audio Slot Transmitter

This block places up to eight parallel PCM channel words onto a shared single-wire audio serial data line. It is a bus target: the bit clock and frame sync arrive from outside and are oversampled by the system clock. A small write-only register port selects the framing (time-division multiplexed, I2S or left-justified), the word length, a slot number for each channel, a start offset in bit clocks, and the polarity of both incoming clocks. The data line has its own output enable, so that several transmitters can share one wire and each one drives only the bit times of the slots it owns.

All eight channel words are captured together at the start of each frame and held for the rest of that frame. Every bit clock, a four-state sequencer decides which slot and bit the bus is on. A priority lookup then finds the channel that owns that slot, and the chosen bit and its enable are registered at the launch edge. The states are IDLE (no frame seen yet), DELAY (counting the start offset), SHIFT (inside the slot area) and DONE (past the last slot of the frame or half). The transitions are as follows. Any frame or half-frame start goes to SHIFT when the total delay is zero and to DELAY otherwise. DELAY goes to SHIFT when its count runs out. SHIFT goes to DONE after the last bit of the last slot. IDLE and DONE wait for the next start.

Top module: `pcm_slot_tx`

## Requirements
- R1: Register map on `cfg_addr`. Address 0 holds mode bits [1:0], word-length code bits [3:2], frame-sync invert bit 4 and bit-clock invert bit 5. Address 1 holds the offset in bits [4:0]. Address 2+c holds the slot of channel c in bits [4:0]. Reset gives mode 00, word code 11, no inversion, offset 0 and slot 0 for every channel, so an untouched block sends channel 0 in TDM slot 0 as a 32-bit word. The data line stays undriven during and right after reset.
- R2: Word-length codes 00, 01, 10 and 11 select 16, 20, 24 and 32 bits. Each slot is that wide. A channel's word is sent MSB first, taken from bits [31 -: width] of its 32-bit input.
- R3: Mode 00 (and the reserved 11) is TDM. A frame starts when the effective frame sync is seen high at an effective bit-clock falling edge after being low at the previous one. The first bit of slot 0 is launched on the next falling edge plus the offset. The falling edge of the frame sync is ignored.
- R4: Mode 01 is I2S. The left half starts when the effective frame sync goes low and the right half when it goes high. Data in each half starts one bit clock after the edge, plus the offset.
- R5: Mode 10 is left-justified. The left half starts when the effective frame sync goes high and the right half when it goes low. Data starts on the same falling edge, plus the offset.
- R6: In I2S and left-justified modes, slot codes 0–15 mean left slots 0–15 and codes 16–31 mean right slots 0–15. Each half carries at most 16 slots.
- R7: The offset (0–31) delays the first slot by that many bit clocks in every mode and in both halves.
- R8: The invert bits flip the incoming frame sync and bit clock before use. With bit-clock invert set, data is launched on the rising edge of the pin.
- R9: `sd_oe` is high only during bit times of a slot assigned to some channel, and `sd_o` is 0 whenever `sd_oe` is low. Bits after the 32nd TDM slot, or after the 16th slot of a half, are never driven.
- R10: When several channels hold the same slot, the lowest-numbered channel is sent.
- R11: Channel words are captured at the TDM frame start or at the left-half start. Changes to `ch_data` later in the frame do not reach the line until the next capture.
- R12: `sd_o` and `sd_oe` change only in the cycle that follows a detected effective bit-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus clocks |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| ch_data | input | 256 | Eight 32-bit channel words, channel c at [32c+31:32c] |
| sd_o | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |

## Verification
The hardest case to reach is a frame start that coincides with a bit launch. This happens in left-justified mode with zero offset, where the capture of the channel words and the first bit fall in the same bit clock. It also happens when a channel word changes in the middle of a frame that is already sending it. The stimulus drives complete frames bit clock by bit clock, with zero and non-zero offsets in every mode. It rewrites the channel inputs halfway through some frames, and it runs frames longer than the slot area, so that the last slot, the end of the frame and the capture point are all crossed while data is on the line.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SHIFT,
        ST_DONE
    } tx_state_e;

    localparam logic [1:0] FMT_TDM = 2'b00;
    localparam logic [1:0] FMT_I2S = 2'b01;
    localparam logic [1:0] FMT_LJ  = 2'b10;

    localparam int CFG_DW = 8;

    // word-length code to bit count
    function automatic logic [5:0] word_bits(input logic [1:0] code);
        logic [5:0] n;
        unique case (code)
            2'b00:   n = 6'd16;
            2'b01:   n = 6'd20;
            2'b10:   n = 6'd24;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pst_cfg_regs.sv
module pst_cfg_regs
    import pst_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 5,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output logic [1:0]               fmt,
    output logic [1:0]               wcode,
    output logic                     fs_inv,
    output logic                     bclk_inv,
    output logic [SLOT_W-1:0]        offset,
    output logic [NUM_CH*SLOT_W-1:0] slot_cfg
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OFFS = ADDR_W'(1);
    localparam int                A_SLOT = 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt      <= FMT_TDM;
            wcode    <= 2'b11;
            fs_inv   <= 1'b0;
            bclk_inv <= 1'b0;
            offset   <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == A_CTRL) begin
                fmt      <= cfg_wdata[1:0];
                wcode    <= cfg_wdata[3:2];
                fs_inv   <= cfg_wdata[4];
                bclk_inv <= cfg_wdata[5];
            end
            if (cfg_addr == A_OFFS) begin
                offset <= cfg_wdata[SLOT_W-1:0];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        logic [SLOT_W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (cfg_wr && cfg_addr == ADDR_W'(A_SLOT + c)) begin
                slot_q <= cfg_wdata[SLOT_W-1:0];
            end
        end
        assign slot_cfg[c*SLOT_W +: SLOT_W] = slot_q;
    end

endmodule

// File: rtl/pst_edge_sync.sv
module pst_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic bclk_inv,
    input  logic fs_inv,
    output logic tick,
    output logic fs_eff
);

    logic b_s1, b_s2, f_s1, f_s2, b_prev;
    logic b_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_s1   <= 1'b0;
            b_s2   <= 1'b0;
            f_s1   <= 1'b0;
            f_s2   <= 1'b0;
            b_prev <= 1'b0;
        end else begin
            b_s1   <= bclk_in;
            b_s2   <= b_s1;
            f_s1   <= fsync_in;
            f_s2   <= f_s1;
            b_prev <= b_eff;
        end
    end

    assign b_eff  = b_s2 ^ bclk_inv;
    assign fs_eff = f_s2 ^ fs_inv;
    assign tick   = b_prev & ~b_eff;

endmodule

// File: rtl/pst_slot_owner.sv
module pst_slot_owner #(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 5,
    parameter int CH_W   = 3
) (
    input  logic [NUM_CH*SLOT_W-1:0] slot_cfg,
    input  logic [SLOT_W-1:0]        code,
    output logic                     hit,
    output logic [CH_W-1:0]          idx
);

    // scan downward so the lowest matching channel is the last written
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (slot_cfg[c*SLOT_W +: SLOT_W] == code) begin
                hit = 1'b1;
                idx = CH_W'(c);
            end
        end
    end

endmodule

// File: rtl/pst_serializer.sv
module pst_serializer
    import pst_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 5,
    parameter int WORD_W = 32,
    parameter int CH_W   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     fs_eff,
    input  logic [1:0]               fmt,
    input  logic [1:0]               wcode,
    input  logic [SLOT_W-1:0]        offset,
    input  logic [NUM_CH*WORD_W-1:0] ch_data,
    input  logic                     owner_hit,
    input  logic [CH_W-1:0]          owner_idx,
    output logic [SLOT_W-1:0]        lookup_code,
    output logic                     sd_o,
    output logic                     sd_oe
);

    localparam int CNT_W = SLOT_W + 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int HALF  = 1 << (SLOT_W - 1);

    tx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     rem_q, rem_d;
    logic [SLOT_W-1:0]    slot_q, slot_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic                 half_q, half_d;
    logic                 fsp_q;
    logic [NUM_CH*WORD_W-1:0] shadow_q;

    logic                 is_tdm, fs_rise, fs_fall;
    logic                 frame_evt, right_evt, start;
    logic [5:0]           wl;
    logic [BIT_W-1:0]     first_bit;
    logic [CNT_W-1:0]     delay;
    logic [SLOT_W-1:0]    last_slot;
    logic [NUM_CH*WORD_W-1:0] src;
    logic [WORD_W-1:0]    word;
    logic [BIT_W-1:0]     sel;
    logic                 drive;

    assign is_tdm  = !(fmt == FMT_I2S || fmt == FMT_LJ);
    assign fs_rise = tick & fs_eff & ~fsp_q;
    assign fs_fall = tick & ~fs_eff & fsp_q;

    always_comb begin
        frame_evt = 1'b0;
        right_evt = 1'b0;
        if (fmt == FMT_I2S) begin
            frame_evt = fs_fall;
            right_evt = fs_rise;
        end else if (fmt == FMT_LJ) begin
            frame_evt = fs_rise;
            right_evt = fs_fall;
        end else begin
            frame_evt = fs_rise;
        end
    end

    assign start     = frame_evt | right_evt;
    assign wl        = word_bits(wcode);
    assign first_bit = BIT_W'(wl - 6'd1);
    assign delay     = CNT_W'(offset) + CNT_W'(fmt != FMT_LJ);
    assign last_slot = is_tdm ? {SLOT_W{1'b1}} : SLOT_W'(HALF - 1);

    // next-state process
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        slot_d  = slot_q;
        bit_d   = bit_q;
        half_d  = half_q;
        if (tick) begin
            if (start) begin
                half_d = right_evt;
                slot_d = '0;
                bit_d  = first_bit;
                if (delay == '0) begin
                    state_d = ST_SHIFT;
                end else begin
                    state_d = ST_DELAY;
                    rem_d   = delay;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: state_d = ST_IDLE;
                    ST_DONE: state_d = ST_DONE;
                    ST_DELAY: begin
                        if (rem_q == CNT_W'(1)) begin
                            state_d = ST_SHIFT;
                            slot_d  = '0;
                            bit_d   = first_bit;
                        end else begin
                            rem_d = rem_q - CNT_W'(1);
                        end
                    end
                    ST_SHIFT: begin
                        if (bit_q == '0) begin
                            if (slot_q == last_slot) begin
                                state_d = ST_DONE;
                            end else begin
                                slot_d = slot_q + SLOT_W'(1);
                                bit_d  = first_bit;
                            end
                        end else begin
                            bit_d = bit_q - BIT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign lookup_code = is_tdm ? slot_d : {half_d, slot_d[SLOT_W-2:0]};
    assign src   = frame_evt ? ch_data : shadow_q;
    assign word  = src[owner_idx*WORD_W +: WORD_W];
    assign sel   = BIT_W'(WORD_W - int'(wl) + int'(bit_d));
    assign drive = (state_d == ST_SHIFT) && owner_hit;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rem_q    <= '0;
            slot_q   <= '0;
            bit_q    <= '0;
            half_q   <= 1'b0;
            fsp_q    <= 1'b0;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
            half_q  <= half_d;
            if (tick) fsp_q <= fs_eff;
            if (tick && frame_evt) shadow_q <= ch_data;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_oe <= 1'b0;
            sd_o  <= 1'b0;
        end else if (tick) begin
            sd_oe <= drive;
            sd_o  <= drive & word[sel];
        end
    end

    p_oe_in_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> state_q == ST_SHIFT);

    p_quiet_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_o);

    p_launch_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sd_oe) && $stable(sd_o));

    p_half_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !is_tdm) |-> slot_q < SLOT_W'(HALF));

    p_delay_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DELAY |-> rem_q != '0);

    p_lj_same_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt && fmt == FMT_LJ && offset == '0)
            |=> state_q == ST_SHIFT && slot_q == '0 && !half_q);

    p_i2s_one_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt && fmt == FMT_I2S) |=> state_q == ST_DELAY && !half_q);

endmodule

// File: rtl/pcm_slot_tx.sv
module pcm_slot_tx
    import pst_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int SLOT_W = 5,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    input  logic                     bclk_in,
    input  logic                     fsync_in,
    input  logic [NUM_CH*WORD_W-1:0] ch_data,
    output logic                     sd_o,
    output logic                     sd_oe
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [1:0]               fmt, wcode;
    logic                     fs_inv, bclk_inv;
    logic [SLOT_W-1:0]        offset;
    logic [NUM_CH*SLOT_W-1:0] slot_cfg;
    logic                     tick, fs_eff;
    logic [SLOT_W-1:0]        lookup_code;
    logic                     owner_hit;
    logic [CH_W-1:0]          owner_idx;

    pst_cfg_regs #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fmt(fmt), .wcode(wcode), .fs_inv(fs_inv),
        .bclk_inv(bclk_inv), .offset(offset), .slot_cfg(slot_cfg)
    );

    pst_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv), .tick(tick), .fs_eff(fs_eff)
    );

    pst_slot_owner #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_W(CH_W)) u_owner (
        .slot_cfg(slot_cfg), .code(lookup_code), .hit(owner_hit), .idx(owner_idx)
    );

    pst_serializer #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .CH_W(CH_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fs_eff(fs_eff), .fmt(fmt),
        .wcode(wcode), .offset(offset), .ch_data(ch_data), .owner_hit(owner_hit),
        .owner_idx(owner_idx), .lookup_code(lookup_code), .sd_o(sd_o), .sd_oe(sd_oe)
    );

endmodule

// File: tb/pcm_slot_tx_tb_top.sv
module pcm_slot_tx_tb_top;

    localparam int NCH = 8;
    localparam int WW  = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              cfg_wr;
    logic [3:0]        cfg_addr;
    logic [7:0]        cfg_wdata;
    logic              bclk_pin, fsync_pin;
    logic [NCH*WW-1:0] ch_data;
    logic              sd_o, sd_oe;

    pcm_slot_tx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bclk_in(bclk_pin), .fsync_in(fsync_pin),
        .ch_data(ch_data), .sd_o(sd_o), .sd_oe(sd_oe)
    );

    // reference model state
    int          fmt_m, wl_m, off_m, t_m;
    bit          binv_m, finv_m, fsp_m, half_m, cmp_en, pend, exp_oe, exp_d, finished;
    int          slot_m [NCH];
    logic [31:0] cur [NCH];
    logic [31:0] lat [NCH];
    int          checks, errors;

    always_comb begin
        for (int c = 0; c < NCH; c++) ch_data[c*WW +: WW] = cur[c];
    end

    function automatic int wlen_of(int code);
        return (code == 0) ? 16 : (code == 1) ? 20 : (code == 2) ? 24 : 32;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        cmp_en = 1'b0; pend = 1'b1;
    endtask

    task automatic set_ctrl(input int f, input int w, input bit fi, input bit bi);
        wr(4'd0, {2'b00, bi, fi, 2'(w), 2'(f)});
        fmt_m = f; wl_m = wlen_of(w); finv_m = fi; binv_m = bi;
    endtask

    task automatic set_off(input int o);
        wr(4'd1, 8'(o)); off_m = o;
    endtask

    task automatic set_slot(input int c, input int s);
        wr(4'(2 + c), 8'(s)); slot_m[c] = s;
    endtask

    task automatic model_tick(input bit fs);
        bit rise, fall, st, fst, hf;
        int dly, pos, sl, nsl, code;
        rise = fs && !fsp_m; fall = !fs && fsp_m; fsp_m = fs;
        st = 0; fst = 0; hf = 0;
        if (fmt_m == 1) begin
            if (fall) begin st = 1; fst = 1; end
            if (rise) begin st = 1; hf = 1; end
        end else if (fmt_m == 2) begin
            if (rise) begin st = 1; fst = 1; end
            if (fall) begin st = 1; hf = 1; end
        end else if (rise) begin
            st = 1; fst = 1;
        end
        if (st) begin
            t_m = 0; half_m = hf;
            if (fst) begin
                for (int c = 0; c < NCH; c++) lat[c] = cur[c];
                if (pend) begin cmp_en = 1; pend = 0; end
            end
        end else if (t_m >= 0 && t_m < 100000) begin
            t_m++;
        end
        exp_oe = 0; exp_d = 0;
        if (t_m >= 0) begin
            dly = off_m + ((fmt_m == 2) ? 0 : 1);
            pos = t_m - dly;
            nsl = (fmt_m == 1 || fmt_m == 2) ? 16 : 32;
            if (pos >= 0) begin
                sl = pos / wl_m;
                if (sl < nsl) begin
                    code = (nsl == 16) ? (int'(half_m) * 16 + sl) : sl;
                    for (int c = NCH - 1; c >= 0; c--) begin
                        if (slot_m[c] == code) begin
                            exp_oe = 1;
                            exp_d  = lat[c][31 - (pos % wl_m)];
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if ({sd_oe, sd_o} !== {exp_oe, exp_oe & exp_d}) begin
            errors++;
            $display("FAIL %s: oe,data actual %b%b expected %b%b (bit time %0d)",
                     tag, sd_oe, sd_o, exp_oe, exp_oe & exp_d, t_m);
        end
    endtask

    // one bit clock: effective falling phase then rising phase
    task automatic do_bit(input bit fs, input string tag);
        @(negedge clk);
        bclk_pin = binv_m; fsync_pin = fs ^ finv_m;
        model_tick(fs);
        repeat (3) @(negedge clk);
        if (cmp_en) check(tag);
        @(negedge clk);
        bclk_pin = ~binv_m;
        repeat (3) @(negedge clk);
        if (cmp_en) check(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_bit(fmt_m == 1, "idle");
    endtask

    task automatic run_frame(input int len, input string tag, input bit chg);
        bit fs;
        for (int i = 0; i < len; i++) begin
            if (fmt_m == 1)      fs = (i >= len / 2);
            else if (fmt_m == 2) fs = (i < len / 2);
            else                 fs = (i == 0);
            if (chg && i == len / 2) begin
                for (int c = 0; c < NCH; c++) cur[c] = {cur[c][30:0], cur[c][31]} ^ 32'hA5A5_0F0F;
            end
            do_bit(fs, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0; errors = 0; finished = 0;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        bclk_pin = 1'b1; fsync_pin = 1'b0;
        fmt_m = 0; wl_m = 32; off_m = 0; binv_m = 0; finv_m = 0;
        t_m = -1; fsp_m = 0; half_m = 0; cmp_en = 0; pend = 1;
        for (int c = 0; c < NCH; c++) begin
            slot_m[c] = 0;
            cur[c] = (32'h1357_9BDF * (c + 1)) ^ 32'h8C3A_5E71;
            lat[c] = '0;
        end
        repeat (5) @(negedge clk);
        checks++;
        if (sd_oe !== 1'b0 || sd_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset oe,data actual %b%b expected 00", sd_oe, sd_o);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (sd_oe !== 1'b0) begin
            errors++;
            $display("FAIL R9: idle after reset oe actual %b expected 0", sd_oe);
        end

        // R1 defaults: TDM, 32-bit, every channel on slot 0 (R10: channel 0 wins)
        idle(3);
        run_frame(80, "R1/R10", 0);
        run_frame(80, "R1/R3", 0);

        // R2 R9 R10 R11: 16-bit TDM, duplicate slot 31, frame past 32 slots
        set_ctrl(0, 0, 0, 0);
        set_slot(0, 3);  set_slot(1, 0);  set_slot(2, 31); set_slot(3, 31);
        set_slot(4, 5);  set_slot(5, 6);  set_slot(6, 9);  set_slot(7, 20);
        idle(2);
        run_frame(560, "R2/R9/R10", 0);
        run_frame(560, "R11", 1);

        // R7 with 20-bit words
        set_ctrl(0, 1, 0, 0);
        set_off(7);
        set_slot(0, 0); set_slot(1, 1); set_slot(2, 2); set_slot(3, 4);
        idle(2);
        run_frame(200, "R2/R3/R7", 0);
        run_frame(200, "R7/R11", 1);

        // R7 maximum offset, 24-bit words
        set_ctrl(0, 2, 0, 0);
        set_off(31);
        idle(2);
        run_frame(150, "R7", 1);
        run_frame(150, "R7/R2", 0);

        // R4 R6: I2S halves
        set_ctrl(1, 0, 0, 0);
        set_off(0);
        set_slot(0, 0);  set_slot(1, 16); set_slot(2, 1);  set_slot(3, 17);
        set_slot(4, 15); set_slot(5, 31); set_slot(6, 2);  set_slot(7, 18);
        idle(2);
        run_frame(80, "R4/R6", 0);
        run_frame(80, "R4/R11", 1);

        // R5: left-justified, zero offset, 24-bit
        set_ctrl(2, 2, 0, 0);
        idle(2);
        run_frame(120, "R5/R11", 1);
        run_frame(120, "R5/R6", 0);

        // R5 R7: left-justified with offset
        set_ctrl(2, 0, 0, 0);
        set_off(5);
        idle(2);
        run_frame(100, "R5/R7", 0);
        run_frame(100, "R5/R7", 0);

        // R8: both polarities inverted, I2S then TDM
        set_ctrl(1, 0, 1, 1);
        set_off(2);
        idle(2);
        run_frame(80, "R8/R4", 0);
        run_frame(80, "R8", 0);
        set_ctrl(0, 0, 1, 1);
        idle(2);
        run_frame(100, "R8/R3", 0);

        // R6 R9: I2S halves longer than 16 slots
        set_ctrl(1, 0, 0, 0);
        set_off(0);
        idle(2);
        run_frame(540, "R6/R9", 0);
        run_frame(540, "R6/R12", 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule